// File: doc/BRIEF.md
# Serial EEPROM Random-Read Sequencer

This block fetches one byte from a serial EEPROM, such as a memory module's configuration store, without software. It sits in front of a status-code I2C master controller and drives that controller through its small register interface. A one-cycle `go` pulse starts a read and latches an 11-bit byte address. The upper three address bits select the device page and the lower eight bits form the word address.

For each read the sequencer brings the controller up: soft reset, clock divider, enable. It then runs a random read. That is a dummy write that loads the word address, then a repeated START, a one-byte read answered with NACK, and a STOP. After each bus step it polls the controller's interrupt flag. Once the flag is set it reads the status code and compares it with the single code that step must produce. Any other code abandons the transfer: the sequencer goes straight to STOP and returns an all-ones result with `error` set.

The controller has one access port. At most one register access is made per cycle, and read data is taken one cycle after the read strobe.

Top module: `i2crr_eeprom_reader`

## Requirements
- R1: After reset `done`, `error`, `data`, `bus_wr` and `bus_rd` are all zero.
- R2: An accepted `go` first writes 0x00 to the soft-reset register (index 3), then 0x24 to the status/divider register (index 2), then 0x40 to the control register (index 0), before any other access.
- R3: Control byte encoding: enable 0x40, START 0x20, STOP 0x10, interrupt flag 0x08, acknowledge 0x04. The acknowledge bit is never written as one, so the single data byte is answered with NACK.
- R4: After initialisation, a fully successful read writes exactly the following, in order. Control 0x60. Data register (index 1) with the write device byte. Control 0x40. Data with the word address. Control 0x40. Control 0x68. Control 0x60. Data with the read device byte. Control 0x40. Control 0x40. Then control 0x58 and control 0x50.
- R5: The write device byte is 0xA0 with address bits [10:8] in bits [3:1]. The read device byte is the same value with bit 0 set. The word address byte is address bits [7:0].
- R6: After each step's control write, the control register is read repeatedly until bit 3 reads one. Only then is the status register read, once.
- R7: The six steps must report 0x08, 0x18, 0x28, 0x10, 0x40 and 0x58 in that order. When all match, the data register is read and its value is returned with `error` low.
- R8: A status that differs from the expected code stops the sequence: no later step's writes occur, control 0x58 then 0x50 is written, and the result is `data`=0xFF with `error` high.
- R9: For the repeated START, START is set while the flag is kept (0x68) before the flag is cleared (0x60).
- R10: `done` is high for exactly one cycle, in the cycle after the 0x50 control write. `data` and `error` keep their value until the next read finishes.
- R11: A `go` that arrives while a read is in progress is ignored: it changes neither the access sequence nor the address used.
- R12: `bus_wr` and `bus_rd` are never high together. Read data on `bus_rdata` is consumed in the cycle after the `bus_rd` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a read (one-cycle pulse) |
| addr | input | 11 | Byte address: [10:8] page, [7:0] word |
| bus_wr | output | 1 | Controller register write strobe |
| bus_rd | output | 1 | Controller register read strobe |
| bus_addr | output | 2 | Controller register index |
| bus_wdata | output | 8 | Controller register write data |
| bus_rdata | input | 8 | Controller read data, valid the cycle after `bus_rd` |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last read aborted on a status mismatch |
| data | output | 8 | Last read result (0xFF on error) |

## Verification
The bench targets the abort path at the first, a middle, the repeated-START and the final step. A sequencer that checked the wrong code, or kept going after a mismatch, would emit extra writes or return the device byte instead of 0xFF. The controller model makes the flag wait for several polls, so a design that read the status without waiting would sample a stale code. Page bits at both extremes catch a mis-shifted device byte. A second `go` fired mid-read, with a different address, exposes a design that restarts or relatches the address.

// File: rtl/i2crr_pkg.sv
package i2crr_pkg;
  localparam int PAGE_W  = 3;
  localparam int WORD_W  = 8;
  localparam int ADDR_W  = PAGE_W + WORD_W;
  localparam int REG_AW  = 2;
  localparam int NSTEPS  = 6;
  localparam int STEP_W  = $clog2(NSTEPS);

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL = 2'd0,
    REG_DATA = 2'd1,
    REG_STAT = 2'd2,
    REG_SRST = 2'd3
  } reg_sel_e;

  // control-register bit values decoded by the controller
  localparam logic [7:0] CB_EN    = 8'h40;
  localparam logic [7:0] CB_START = 8'h20;
  localparam logic [7:0] CB_STOP  = 8'h10;
  localparam logic [7:0] CB_FLAG  = 8'h08;
  localparam logic [7:0] CB_ACK   = 8'h04;
  localparam logic [7:0] DIV_INIT = 8'h24;
  localparam logic [7:0] ERR_VAL  = 8'hFF;

  typedef struct packed {
    logic       has_data;
    logic [7:0] data;
    logic [7:0] ctrl1;
    logic       has_ctrl2;
    logic [7:0] ctrl2;
    logic [7:0] want;
  } step_t;

  // device select byte: fixed type nibble, page, direction
  function automatic logic [7:0] dev_byte(input logic [PAGE_W-1:0] page,
                                          input logic rd);
    return {4'hA, page, rd};
  endfunction
endpackage

// File: rtl/i2crr_step_rom.sv
module i2crr_step_rom
  import i2crr_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] addr,
  output step_t             desc
);
  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1:WORD_W];

  always_comb begin
    desc = '0;
    case (step)
      3'd0: begin  // START
        desc.ctrl1 = CB_EN | CB_START;
        desc.want  = 8'h08;
      end
      3'd1: begin  // device select, write
        desc.has_data = 1'b1;
        desc.data     = dev_byte(page, 1'b0);
        desc.ctrl1    = CB_EN;
        desc.want     = 8'h18;
      end
      3'd2: begin  // word address
        desc.has_data = 1'b1;
        desc.data     = addr[WORD_W-1:0];
        desc.ctrl1    = CB_EN;
        desc.want     = 8'h28;
      end
      3'd3: begin  // repeated START: set START, then clear flag
        desc.ctrl1     = CB_EN | CB_START | CB_FLAG;
        desc.has_ctrl2 = 1'b1;
        desc.ctrl2     = CB_EN | CB_START;
        desc.want      = 8'h10;
      end
      3'd4: begin  // device select, read
        desc.has_data = 1'b1;
        desc.data     = dev_byte(page, 1'b1);
        desc.ctrl1    = CB_EN;
        desc.want     = 8'h40;
      end
      3'd5: begin  // one byte, acknowledge bit left clear -> NACK
        desc.ctrl1 = CB_EN;
        desc.want  = 8'h58;
      end
      default: desc = '0;
    endcase
  end
endmodule

// File: rtl/i2crr_fsm.sv
module i2crr_fsm
  import i2crr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  input  step_t             desc,
  output logic [STEP_W-1:0] step_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [REG_AW-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              done,
  output logic              error,
  output logic [7:0]        data
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_DIV, ST_EN, ST_SDATA, ST_SC1, ST_SC2,
    ST_PRD, ST_PCHK, ST_SRD, ST_SCHK, ST_DRD, ST_DCAP,
    ST_STOPS, ST_STOPC, ST_DONE
  } state_e;

  state_e     state;
  logic       err_q;
  logic [7:0] data_q;

  // named events used by the sequencing and the assertions
  logic flag_seen, status_ok, status_bad, last_step, busy;
  assign flag_seen  = (state == ST_PCHK) && ((bus_rdata & CB_FLAG) != 8'h00);
  assign status_ok  = (state == ST_SCHK) && (bus_rdata == desc.want);
  assign status_bad = (state == ST_SCHK) && (bus_rdata != desc.want);
  assign last_step  = (step_q == STEP_W'(NSTEPS - 1));
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      step_q <= '0;
      addr_q <= '0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (go) begin
                    addr_q <= addr;
                    step_q <= '0;
                    state  <= ST_RST;
                  end
        ST_RST:   state <= ST_DIV;
        ST_DIV:   state <= ST_EN;
        ST_EN:    state <= ST_SDATA;
        ST_SDATA: state <= ST_SC1;
        ST_SC1:   state <= desc.has_ctrl2 ? ST_SC2 : ST_PRD;
        ST_SC2:   state <= ST_PRD;
        ST_PRD:   state <= ST_PCHK;
        ST_PCHK:  state <= flag_seen ? ST_SRD : ST_PRD;
        ST_SRD:   state <= ST_SCHK;
        ST_SCHK: begin
          if (status_bad) begin
            err_q  <= 1'b1;
            data_q <= ERR_VAL;
            state  <= ST_STOPS;
          end else if (last_step) begin
            state <= ST_DRD;
          end else begin
            step_q <= step_q + 1'b1;
            state  <= ST_SDATA;
          end
        end
        ST_DRD:   state <= ST_DCAP;
        ST_DCAP: begin
          data_q <= bus_rdata;
          err_q  <= 1'b0;
          state  <= ST_STOPS;
        end
        ST_STOPS: state <= ST_STOPC;
        ST_STOPC: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = REG_CTRL;
    bus_wdata = 8'h00;
    case (state)
      ST_RST:   begin bus_wr = 1'b1; bus_addr = REG_SRST; end
      ST_DIV:   begin bus_wr = 1'b1; bus_addr = REG_STAT; bus_wdata = DIV_INIT; end
      ST_EN:    begin bus_wr = 1'b1; bus_wdata = CB_EN; end
      ST_SDATA: begin bus_wr = desc.has_data; bus_addr = REG_DATA; bus_wdata = desc.data; end
      ST_SC1:   begin bus_wr = 1'b1; bus_wdata = desc.ctrl1; end
      ST_SC2:   begin bus_wr = 1'b1; bus_wdata = desc.ctrl2; end
      ST_PRD:   bus_rd = 1'b1;
      ST_SRD:   begin bus_rd = 1'b1; bus_addr = REG_STAT; end
      ST_DRD:   begin bus_rd = 1'b1; bus_addr = REG_DATA; end
      ST_STOPS: begin bus_wr = 1'b1; bus_wdata = CB_EN | CB_STOP | CB_FLAG; end
      ST_STOPC: begin bus_wr = 1'b1; bus_wdata = CB_EN | CB_STOP; end
      default: ;
    endcase
  end

  assign done  = (state == ST_DONE);
  assign error = err_q;
  assign data  = data_q;

  assert_single_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_wr && bus_addr == REG_CTRL && bus_wdata == (CB_EN | CB_STOP)));
  assert_error_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (data == ERR_VAL));
  assert_abort_to_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_bad |=> (bus_wr && bus_addr == REG_CTRL && bus_wdata == (CB_EN | CB_STOP | CB_FLAG)));
  assert_status_after_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_STAT) |-> $past((bus_rdata & CB_FLAG) != 8'h00));
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
  assert_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_CTRL) |-> ((bus_wdata & CB_ACK) == 8'h00));
endmodule

// File: rtl/i2crr_eeprom_reader.sv
module i2crr_eeprom_reader
  import i2crr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic [REG_AW-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic              done,
  output logic              error,
  output logic [7:0]        data
);
  step_t             desc;
  logic [STEP_W-1:0] step_q;
  logic [ADDR_W-1:0] addr_q;

  i2crr_step_rom u_rom (
    .step (step_q),
    .addr (addr_q),
    .desc (desc)
  );

  i2crr_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .addr      (addr),
    .desc      (desc),
    .step_q    (step_q),
    .addr_q    (addr_q),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .done      (done),
    .error     (error),
    .data      (data)
  );
endmodule

// File: tb/i2crr_eeprom_reader_test.sv
`timescale 1ns/1ps
module i2crr_eeprom_reader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [10:0] addr = '0;
  logic        bus_wr, bus_rd, done, error;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata, data;
  logic [7:0]  bus_rdata = 8'h00;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2crr_eeprom_reader uut (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done(done), .error(error), .data(data)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- controller model (register-level responder) ----------
  logic       flag = 1'b0;
  logic [7:0] stat_reg = 8'hF8, data_reg = 8'h00;
  int         timer = 0, delay_cfg = 1, early_stat = 0, bus_act = 0;
  logic [7:0] stat_script[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      timer <= 0;
    end else begin
      if (timer > 0) begin
        if (timer == 1) begin
          flag     <= 1'b1;
          stat_reg <= (stat_script.size() > 0) ? stat_script.pop_front() : 8'hF8;
        end
        timer <= timer - 1;
      end
      if (bus_wr || bus_rd) bus_act <= bus_act + 1;
      if (bus_wr && bus_addr == 2'd0) begin
        if (!bus_wdata[3]) flag <= 1'b0;
        if (!bus_wdata[3] && !bus_wdata[4] && (flag || bus_wdata[5]))
          timer <= delay_cfg;
      end
      if (bus_rd) begin
        case (bus_addr)
          2'd0:    bus_rdata <= flag ? 8'h48 : 8'h40;
          2'd1:    bus_rdata <= data_reg;
          2'd2:    bus_rdata <= stat_reg;
          default: bus_rdata <= 8'h00;
        endcase
        if (bus_addr == 2'd2 && !flag) early_stat <= early_stat + 1;  // R6
      end
    end
  end

  // ---------------- scoreboard of register writes ----------------
  logic [9:0] exp_q[$];
  string      exp_tag[$];
  int         last_wr_cyc = 0;

  always @(posedge clk) begin
    if (rst_n && bus_wr) begin
      last_wr_cyc <= cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected write", {bus_addr, bus_wdata}, 0);
      end else begin
        logic [9:0] e;
        string      t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check({bus_addr, bus_wdata} == e, t, "register write", {bus_addr, bus_wdata}, e);
      end
    end
  end

  task automatic push_wr(input logic [1:0] a, input logic [7:0] d, input string t);
    exp_q.push_back({a, d});
    exp_tag.push_back(t);
  endtask

  // driver: builds the expected writes and result, then starts the read
  task automatic run_read(input logic [10:0] a, input logic [7:0] codes[6],
                          input logic [7:0] byte_in, input int dly,
                          input bit busy_go);
    logic [7:0] want[6];
    logic [7:0] dev_w, exp_data;
    int k, wait_n;
    bit exp_err;
    want = '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58};
    k = 6;
    for (int i = 0; i < 6; i++) if (k == 6 && codes[i] != want[i]) k = i;
    dev_w    = 8'hA0 | {4'b0000, a[10:8], 1'b0};           // R5
    exp_err  = (k != 6);
    exp_data = exp_err ? 8'hFF : byte_in;
    // R2: initialisation order
    push_wr(2'd3, 8'h00, "R2"); push_wr(2'd2, 8'h24, "R2"); push_wr(2'd0, 8'h40, "R2");
    for (int s = 0; s < 6; s++) begin
      if (s <= k) begin
        case (s)
          0: push_wr(2'd0, 8'h60, "R4");
          1: begin push_wr(2'd1, dev_w, "R5"); push_wr(2'd0, 8'h40, "R4"); end
          2: begin push_wr(2'd1, a[7:0], "R5"); push_wr(2'd0, 8'h40, "R4"); end
          3: begin push_wr(2'd0, 8'h68, "R9"); push_wr(2'd0, 8'h60, "R9"); end
          4: begin push_wr(2'd1, dev_w | 8'h01, "R5"); push_wr(2'd0, 8'h40, "R4"); end
          default: push_wr(2'd0, 8'h40, "R3");
        endcase
      end
    end
    push_wr(2'd0, 8'h58, exp_err ? "R8" : "R4");
    push_wr(2'd0, 8'h50, exp_err ? "R8" : "R4");
    for (int i = 0; i < 6; i++) if (i <= k) stat_script.push_back(codes[i]);
    data_reg  = byte_in;
    delay_cfg = dly;
    early_stat = 0;

    @(negedge clk); addr = a; go = 1'b1;
    @(negedge clk); go = 1'b0; addr = ~a;
    if (busy_go) begin
      repeat (20) @(negedge clk);
      go = 1'b1; addr = a ^ 11'h5A5;                       // R11
      @(negedge clk); go = 1'b0;
    end
    wait_n = 0;
    while (!done && wait_n < 5000) begin @(negedge clk); wait_n++; end
    check(done == 1'b1, "R10", "done seen", done, 1);
    // monitor side: compare the produced result
    check(error == exp_err, exp_err ? "R8" : "R7", "error flag", error, exp_err);
    check(data == exp_data, exp_err ? "R8" : "R7", "data", data, exp_data);
    check(last_wr_cyc == cyc - 1, "R10", "done follows STOP clear", last_wr_cyc, cyc - 1);
    check(exp_q.size() == 0, "R4", "writes left over", exp_q.size(), 0);
    check(early_stat == 0, "R6", "status read before flag", early_stat, 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done single cycle", done, 0);
    bus_act = 0;
    repeat (10) @(negedge clk);
    check(bus_act == 0, "R11", "bus quiet after done", bus_act, 0);
    check(data == exp_data && error == exp_err, "R10", "result held", data, exp_data);
    exp_q.delete(); exp_tag.delete(); stat_script.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0 && error == 1'b0, "R1", "done/error", {done, error}, 0);
    check(data == 8'h00, "R1", "data", data, 0);
    check(bus_wr == 1'b0 && bus_rd == 1'b0, "R1", "bus idle", {bus_wr, bus_rd}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R7 successes with page bits at extremes (R5)
    run_read(11'h000, '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58}, 8'h5A, 1, 1'b0);
    run_read(11'h7FF, '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58}, 8'hC3, 4, 1'b0);
    run_read(11'h2A5, '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58}, 8'h00, 2, 1'b0);
    // R8 aborts at first, middle, repeated-START and last steps
    run_read(11'h123, '{8'h00, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58}, 8'h11, 2, 1'b0);
    run_read(11'h456, '{8'h08, 8'h18, 8'h30, 8'h10, 8'h40, 8'h58}, 8'h22, 3, 1'b0);
    run_read(11'h5F0, '{8'h08, 8'h18, 8'h28, 8'h08, 8'h40, 8'h58}, 8'h33, 1, 1'b0);
    run_read(11'h30C, '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h50}, 8'h44, 2, 1'b0);
    // R11: second go during a read
    run_read(11'h1B7, '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58}, 8'h9E, 3, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule